// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked digital monostable. It watches three asynchronous control lines and, when one of them shows a qualified edge, raises a pulse whose length is a number of clock cycles taken from a width input. The three control lines are a falling-edge trigger, a rising-edge trigger and an active-low clear. The clear line does two jobs. While it is low it ends any pulse and blocks all triggering. Its rising edge is also a trigger path of its own.

Each trigger path is gated by the synchronized levels of the other two lines in the same cycle. If a qualified trigger arrives while a pulse is running, the counter reloads to the full width, so the pulse can be stretched for as long as triggers keep coming. The block drives the pulse on one output and its complement on a second output. A synchronous system reset brings the block to idle. The block makes no trigger out of whatever levels the control lines hold when that reset is released.

Top module: `retrig_oneshot`

## Requirements
- R1: While `rst` is high and after it falls, `pulse_o` is 0. Levels held on the control lines across reset release (fall trigger 0, rise trigger 1, clear 1) start no pulse.
- R2: A 1-to-0 change on `trig_fall_i` starts a pulse only if `trig_rise_i` is 1 and `clear_n_i` is 1. The pulse is first seen high after the third rising clock edge that follows the input change.
- R3: A 0-to-1 change on `trig_rise_i` starts a pulse only if `trig_fall_i` is 0 and `clear_n_i` is 1.
- R4: A 0-to-1 change on `clear_n_i` starts a pulse when `trig_fall_i` is 0 and `trig_rise_i` is 1.
- R5: An edge on one trigger line whose gating levels are not met produces no pulse.
- R6: When `clear_n_i` goes low, a running pulse ends with the same three-edge latency as a trigger, and no edge on any line starts a pulse while it stays low.
- R7: A qualified trigger during a pulse reloads the full width. Total high time is the width plus the cycles between the first trigger and the last retrigger.
- R8: `width_i` is sampled on the trigger cycle. A pulse lasts exactly that many cycles, and a width of 0 gives no pulse.
- R9: Steady levels never start a pulse. A trigger line returning to its idle level mid-pulse does not shorten the pulse.
- R10: `pulse_n_o` is always the complement of `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| trig_fall_i | input | 1 | Asynchronous trigger, acts on its falling edge |
| trig_rise_i | input | 1 | Asynchronous trigger, acts on its rising edge |
| clear_n_i | input | 1 | Asynchronous clear, active low; its rising edge also triggers |
| width_i | input | W | Pulse length in clock cycles |
| pulse_o | output | 1 | Pulse output, high while a pulse runs |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The bench holds the gating levels that would make a clear-edge trigger across reset release. A design that fails to mask stale edge history would then fire a pulse with no edge present. It drives edges with the wrong gating levels, and it drives triggers while the clear line is held low. A design that gates on raw instead of synchronized levels, or lets clear only end pulses, would emit pulses there. It retriggers mid-pulse and clears mid-pulse, and it counts high cycles. A counter that does not reload, or a clear that does not cut the pulse, would show a different high-cycle total. It also issues a zero-width trigger and returns a trigger line to idle mid-pulse, where an off-by-one counter or a level-sensitive trigger would show up as a wrong pulse length.

// File: rtl/retrig_pkg.sv
package retrig_pkg;

    // Synchronized levels of the three control lines
    typedef struct packed {
        logic fall;   // falling-edge trigger line
        logic rise;   // rising-edge trigger line
        logic clr_n;  // active-low clear, rising edge also triggers
    } trig_lvl_t;

    localparam int LVL_W = $bits(trig_lvl_t);

endpackage

// File: rtl/retrig_sync.sv
module retrig_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/retrig_trigger.sv
module retrig_trigger
    import retrig_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  trig_lvl_t lvl_i,
    output logic      trig_o,
    output logic      clr_o
);

    // Cycles after reset before edge history holds real samples
    localparam int LIM = STAGES + 1;
    localparam int RW  = $clog2(LIM + 1);

    typedef struct packed {
        trig_lvl_t     prev;
        logic [RW-1:0] warm;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       ready;
    logic       fall_hit, rise_hit, clr_hit;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        if (st_q.warm != RW'(LIM)) begin
            st_d.warm = st_q.warm + 1'b1;
        end

        ready    = (st_q.warm == RW'(LIM));
        fall_hit =  st_q.prev.fall  & ~lvl_i.fall  & lvl_i.rise  & lvl_i.clr_n;
        rise_hit = ~st_q.prev.rise  &  lvl_i.rise  & ~lvl_i.fall & lvl_i.clr_n;
        clr_hit  = ~st_q.prev.clr_n &  lvl_i.clr_n & ~lvl_i.fall & lvl_i.rise;

        trig_o = ready & (fall_hit | rise_hit | clr_hit);
        clr_o  = ~lvl_i.clr_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/retrig_timer.sv
module retrig_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig_i,
    input  logic         clr_i,
    input  logic [W-1:0] width_i,
    output logic [W-1:0] cnt_o,
    output logic         pulse_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (trig_i) begin
            st_d.cnt = width_i;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.pulse = (st_d.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import retrig_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig_fall_i,
    input  logic         trig_rise_i,
    input  logic         clear_n_i,
    input  logic [W-1:0] width_i,
    output logic         pulse_o,
    output logic         pulse_n_o
);

    trig_lvl_t    raw_lvl, sync_lvl;
    logic         trig_w, clr_w, pulse_w;
    logic [W-1:0] cnt_w;

    always_comb begin
        raw_lvl.fall  = trig_fall_i;
        raw_lvl.rise  = trig_rise_i;
        raw_lvl.clr_n = clear_n_i;
    end

    retrig_sync #(.N(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lvl),
        .dout (sync_lvl)
    );

    retrig_trigger #(.STAGES(SYNC_STAGES)) u_det (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (sync_lvl),
        .trig_o (trig_w),
        .clr_o  (clr_w)
    );

    retrig_timer #(.W(W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (trig_w),
        .clr_i   (clr_w),
        .width_i (width_i),
        .cnt_o   (cnt_w),
        .pulse_o (pulse_w)
    );

    assign pulse_o   = pulse_w;
    assign pulse_n_o = ~pulse_w;

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         trig,
    input logic         clr,
    input logic [W-1:0] width,
    input logic [W-1:0] cnt,
    input logic         pulse,
    input logic         pulse_n
);

    // R10
    compl_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_n == ~pulse);

    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pulse);

    // R6
    clr_cut_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pulse);

    // R8
    zero_width_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && width == '0) |=> !pulse);

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && width != '0) |=> (pulse && cnt == $past(width)));

    // R8
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && !trig && !clr) |=> (cnt == $past(cnt) - 1'b1));

    // R9
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig && !pulse) |=> !pulse);

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .trig    (trig_w),
    .clr     (clr_w),
    .width   (width_i),
    .cnt     (cnt_w),
    .pulse   (pulse_o),
    .pulse_n (pulse_n_o)
);

// File: tb/sim_retrig_oneshot.sv
module sim_retrig_oneshot;

    localparam int W        = 8;
    localparam int WDOG_MAX = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         a   = 1'b0;
    logic         b   = 1'b1;
    logic         c   = 1'b1;
    logic [W-1:0] width = 8'd5;
    logic         pulse_o, pulse_n_o;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    bit    armed  = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    retrig_oneshot #(.W(W), .SYNC_STAGES(2)) u0 (
        .clk         (clk),
        .rst         (rst),
        .trig_fall_i (a),
        .trig_rise_i (b),
        .clear_n_i   (c),
        .width_i     (width),
        .pulse_o     (pulse_o),
        .pulse_n_o   (pulse_n_o)
    );

    // Behavioural reference: history of applied inputs, remaining high cycles
    typedef struct packed { logic a; logic b; logic c; } smp_t;
    smp_t hist[$];
    int   remain = 0;
    bit   exp_q  = 1'b0;

    always @(posedge clk) begin
        armed = 1'b1;
        if (rst) begin
            hist.delete();
            remain = 0;
        end else begin
            smp_t now_s, old_s;
            bit   fire;
            hist.push_front('{a: a, b: b, c: c});
            if (hist.size() > 4) void'(hist.pop_back());
            fire = 1'b0;
            if (hist.size() >= 4) begin
                now_s = hist[2];
                old_s = hist[3];
                fire = (old_s.a && !now_s.a && now_s.b && now_s.c) ||
                       (!old_s.b && now_s.b && !now_s.a && now_s.c) ||
                       (!old_s.c && now_s.c && !now_s.a && now_s.b);
            end
            if (hist.size() >= 3 && !hist[2].c) remain = 0;
            else if (fire) remain = int'(width);
            else if (remain > 0) remain = remain - 1;
        end
        exp_q = (remain != 0);
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (pulse_o !== exp_q) begin
                errors++;
                $display("FAIL %s: pulse_o=%0b expected %0b at %0t", cur_req, pulse_o, exp_q, $time);
            end
            checks++;
            if (pulse_n_o !== ~pulse_o) begin
                errors++;
                $display("FAIL R10: pulse_n_o=%0b expected %0b at %0t", pulse_n_o, ~pulse_o, $time);
            end
        end
    end

    task automatic count_high(input int n, output int hits);
        hits = 0;
        repeat (n) begin
            @(negedge clk);
            if (pulse_o) hits++;
        end
    endtask

    task automatic expect_hits(input string req, input int got, input int want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s: high cycles=%0d expected %0d", req, got, want);
        end
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin : wdog
        repeat (WDOG_MAX) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", WDOG_MAX, WDOG_MAX);
            report();
            $finish;
        end
    end

    initial begin : stim
        int h, h2, h3;
        // R1: gating levels for a clear-edge trigger held across reset release
        a = 1'b0; b = 1'b1; c = 1'b1; width = 8'd5;
        repeat (4) @(negedge clk);
        checks++;
        if (pulse_o !== 1'b0 || pulse_n_o !== 1'b1) begin
            errors++;
            $display("FAIL R1: pulse_o=%0b expected 0 during reset", pulse_o);
        end
        rst = 1'b0;
        count_high(10, h);
        expect_hits("R1", h, 0);

        // R9: steady levels, then raise A (rising A is not a trigger)
        cur_req = "R9";
        a = 1'b1;
        count_high(12, h);
        expect_hits("R9", h, 0);

        // R2: falling A with B high, clear high, width 5
        cur_req = "R2";
        a = 1'b0;
        count_high(2, h);
        expect_hits("R2", h, 0);
        count_high(13, h);
        expect_hits("R2", h, 5);

        // R8: zero width yields no pulse
        cur_req = "R8";
        a = 1'b1; width = 8'd0;
        count_high(4, h);
        a = 1'b0;
        count_high(12, h);
        expect_hits("R8", h, 0);

        // R3: rising B with A low, width 7
        cur_req = "R3";
        width = 8'd7; b = 1'b0;
        count_high(4, h);
        b = 1'b1;
        count_high(15, h);
        expect_hits("R3", h, 7);

        // R9: A returns high mid-pulse after a B-triggered pulse
        cur_req = "R9";
        b = 1'b0;
        count_high(4, h);
        b = 1'b1; width = 8'd9;
        count_high(5, h);
        a = 1'b1;
        count_high(14, h2);
        expect_hits("R9", h + h2, 9);

        // R5: B rises while A is high; A falls while B is low
        cur_req = "R5";
        b = 1'b0;
        count_high(4, h);
        b = 1'b1;
        count_high(8, h2);
        b = 1'b0;
        count_high(4, h3);
        a = 1'b0;
        count_high(10, h);
        expect_hits("R5", h + h2 + h3, 0);

        // R4: clear pulse low then high with A low, B high
        cur_req = "R4";
        b = 1'b1; width = 8'd6;
        count_high(4, h);
        c = 1'b0;
        count_high(4, h);
        c = 1'b1;
        count_high(14, h);
        expect_hits("R4", h, 6);

        // R6: clear cuts a long pulse after 5 cycles, then blocks triggers
        cur_req = "R6";
        a = 1'b1; width = 8'd20;
        count_high(4, h);
        a = 1'b0;
        count_high(5, h);
        c = 1'b0;
        count_high(10, h2);
        expect_hits("R6", h + h2, 5);
        a = 1'b1;
        count_high(4, h);
        a = 1'b0;
        count_high(4, h2);
        b = 1'b0;
        count_high(4, h3);
        expect_hits("R6", h + h2 + h3, 0);
        // leave clear with A high so its rising edge is not a trigger
        a = 1'b1; b = 1'b1;
        count_high(4, h);
        c = 1'b1;
        count_high(8, h2);
        expect_hits("R6", h + h2, 0);

        // R7: retrigger 4 cycles after first trigger, width 6 -> 10 cycles
        cur_req = "R7";
        width = 8'd6;
        a = 1'b0;
        count_high(2, h);
        a = 1'b1;
        count_high(2, h2);
        a = 1'b0;
        count_high(16, h3);
        expect_hits("R7", h + h2 + h3, 10);

        // R8: width changed during a pulse has no effect on its length
        cur_req = "R8";
        a = 1'b1; width = 8'd4;
        count_high(4, h);
        a = 1'b0;
        count_high(3, h);
        width = 8'd30;
        count_high(12, h2);
        expect_hits("R8", h + h2, 4);

        // R1: reset in mid-pulse returns to idle
        cur_req = "R1";
        a = 1'b1; width = 8'd30;
        count_high(4, h);
        a = 1'b0;
        count_high(6, h);
        rst = 1'b1;
        count_high(3, h);
        rst = 1'b0;
        count_high(10, h2);
        expect_hits("R1", h2, 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule